// File: doc/BRIEF.md
# Paged Nonvolatile Write Controller

This block models the write side of a byte-wide paged nonvolatile memory in synchronous logic. It takes the host chip-enable, write-enable and output-enable strobes, filters out short glitches, and decides when a write cycle starts and ends. A write cycle captures an address when it starts and a data byte when it ends. Each byte goes into a page register, and a per-byte valid bitmap records which offsets were loaded.

The first accepted byte opens a load window and sets the page. Each further byte restarts an idle timer. When that timer runs out, the window closes and a timed programming phase begins. During this phase the controller walks the bitmap and sends only the loaded bytes to the array through a commit port, one byte per cycle. When the phase ends, the bitmap is cleared. Writes are refused while the supply is not good, during a power-on delay, and while a programming phase is running.

All timing is given in clock cycles through parameters: the glitch filter length, the byte-load timeout, the programming time and the power-on delay.

Top module: `eeprom_page_prog`

## Requirements
- R1: A write cycle starts on either of two strobe orders. In one, write-enable pulses low while chip-enable is low and output-enable is high. In the other, chip-enable pulses low while write-enable is low and output-enable is high. Either order loads one byte.
- R2: The address is sampled when the later of the two enables falls. The data is sampled when the first of the two enables rises. A change of address after the cycle starts has no effect. The data value present at the end of the cycle is the one stored.
- R3: Bytes that arrive less than T_BLC cycles apart join the same page. The page comes from address bits 16..7 of the first byte. Those bits are ignored on later bytes, and their bits 6..0 select the offset.
- R4: Once T_BLC cycles pass without a new byte, the load window closes. A later byte does not join that page.
- R5: The programming phase commits only the loaded offsets. Each commit has address {page, offset}. A repeated offset commits its last value. The bitmap is empty when busy falls.
- R6: A strobe pulse taken while output-enable is low loads nothing.
- R7: A low pulse on chip-enable or write-enable that is shorter than FILT_CYC cycles loads nothing.
- R8: No byte is accepted until supply_good has been high for T_POR consecutive cycles. A drop of supply_good restarts that delay.
- R9: busy rises with the first loaded byte and falls only when the programming phase ends. For a single byte, busy is high for exactly T_BLC + T_WC cycles.
- R10: Strobes that arrive during the programming phase are ignored and start no new page.
- R11: After reset, busy and commit_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_good | input | 1 | High while the supply is in range |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| addr | input | ADDR_W (17) | Byte address; bits 16..7 page, 6..0 offset |
| din | input | DATA_W (8) | Write data |
| busy | output | 1 | High from the first loaded byte until programming ends |
| commit_we | output | 1 | One-cycle array write strobe during programming |
| commit_addr | output | ADDR_W (17) | Array address for the commit |
| commit_data | output | DATA_W (8) | Array data for the commit |

## Verification
The bench builds the block with FILT_CYC=2, T_BLC=40, T_WC=200 and T_POR=100. With these values the power-on lockout and its restart fit in a few hundred cycles. They also let a pulse of one cycle be a glitch while a pulse of six cycles is a valid write. The timeout stays long enough for back-to-back bytes to share a page, and an explicit gap closes the page. The programming time still leaves room for the full 128-offset scan. With these values a whole 128-byte page, random multi-byte pages and an exact busy-duration count all run in a short simulation.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } ctl_st_t;
endpackage

// File: rtl/eepc_glitch_filter.sv
// Per-bit level filter: an output level follows its input only after
// the input has held the new level for FILT_CYC consecutive cycles.
module eepc_glitch_filter #(
   parameter int N        = 3,
   parameter int FILT_CYC = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   output logic [N-1:0] filt
);
   localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);

   generate
      for (genvar g = 0; g < N; g++) begin : g_bit
         logic lvl;
         if (FILT_CYC <= 1) begin : g_pass
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) lvl <= 1'b1;
               else        lvl <= raw[g];
            end
         end else begin : g_cnt
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  lvl <= 1'b1;
                  cnt <= '0;
               end else if (raw[g] == lvl) begin
                  cnt <= '0;
               end else if (cnt == CW'(FILT_CYC - 1)) begin
                  lvl <= raw[g];
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
         assign filt[g] = lvl;
      end
   endgenerate
endmodule

// File: rtl/eepc_strobe_decode.sv
// Turns filtered strobes into a start event (address sample) and a
// qualified end event (byte latch).
module eepc_strobe_decode #(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_f,
   input  logic              we_f,
   input  logic              oe_f,
   input  logic              allow,
   input  logic [ADDR_W-1:0] addr,
   output logic              latch,
   output logic [ADDR_W-1:0] cap_addr
);
   logic active, act_q, armed, start_ev, end_ev;

   assign active   = !ce_f && !we_f && oe_f;
   assign start_ev = active && !act_q;
   assign end_ev   = act_q && !active && oe_f;
   assign latch    = end_ev && armed && allow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         armed    <= 1'b0;
         cap_addr <= '0;
      end else begin
         act_q <= active;
         if (start_ev) begin
            armed    <= allow;
            cap_addr <= addr;
         end else if (end_ev) begin
            armed <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/eepc_por_lock.sv
// Counts cycles of good supply; writes are allowed once T_POR is reached.
module eepc_por_lock #(
   parameter int T_POR = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_good,
   output logic ok
);
   localparam int PW = $clog2(T_POR + 1);
   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!supply_good)        cnt <= '0;
      else if (cnt != PW'(T_POR))   cnt <= cnt + 1'b1;
   end

   assign ok = supply_good && (cnt == PW'(T_POR));
endmodule

// File: rtl/eepc_page_buf.sv
// Page data register with a load-valid bitmap.
module eepc_page_buf #(
   parameter int OFS_W  = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFS_W-1:0]  wr_ofs,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr,
   input  logic [OFS_W-1:0]  rd_ofs,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [(1<<OFS_W)-1:0] vmap
);
   localparam int PB = 1 << OFS_W;
   logic [DATA_W-1:0] mem [PB];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ofs] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vmap <= '0;
      else if (clr)   vmap <= '0;
      else if (wr_en) vmap[wr_ofs] <= 1'b1;
   end

   assign rd_valid = vmap[rd_ofs];
   assign rd_data  = mem[rd_ofs];
endmodule

// File: rtl/eeprom_page_prog.sv
module eeprom_page_prog #(
   parameter int ADDR_W   = 17,
   parameter int DATA_W   = 8,
   parameter int OFS_W    = 7,
   parameter int FILT_CYC = 2,
   parameter int T_BLC    = 7500,
   parameter int T_WC     = 500000,
   parameter int T_POR    = 250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              supply_good,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              busy,
   output logic              commit_we,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data
);
   import eepc_pkg::*;

   localparam int PAGE_BYTES = 1 << OFS_W;
   localparam int PG_W       = ADDR_W - OFS_W;
   localparam int IC_W       = $clog2(T_BLC + 1);
   localparam int PC_W       = $clog2(T_WC + 1);

   generate
      if (ADDR_W <= OFS_W) begin : g_chk_addr
         $error("ADDR_W must exceed OFS_W");
      end
      if (T_BLC < 2) begin : g_chk_blc
         $error("T_BLC must be at least 2");
      end
      if (T_WC <= PAGE_BYTES + 1) begin : g_chk_wc
         $error("T_WC must exceed PAGE_BYTES + 1");
      end
      if (FILT_CYC < 1) begin : g_chk_filt
         $error("FILT_CYC must be at least 1");
      end
   endgenerate

   ctl_st_t           st;
   logic [IC_W-1:0]   idle_cnt;
   logic [PC_W-1:0]   pc;
   logic [PG_W-1:0]   page_q;
   logic [2:0]        filt;
   logic              ce_f, we_f, oe_f;
   logic              por_ok, allow, latch, prog, clr;
   logic [ADDR_W-1:0] cap_addr;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;
   logic [PAGE_BYTES-1:0] load_map;

   eepc_glitch_filter #(.N(3), .FILT_CYC(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n),
      .raw({oe_n, we_n, ce_n}), .filt(filt)
   );
   assign ce_f = filt[0];
   assign we_f = filt[1];
   assign oe_f = filt[2];

   eepc_por_lock #(.T_POR(T_POR)) u_por (
      .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .ok(por_ok)
   );

   assign prog  = (st == ST_PROG);
   assign allow = por_ok && !prog;

   eepc_strobe_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .ce_f(ce_f), .we_f(we_f), .oe_f(oe_f),
      .allow(allow), .addr(addr),
      .latch(latch), .cap_addr(cap_addr)
   );

   assign clr = prog && (pc == PC_W'(T_WC - 1));

   eepc_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(latch), .wr_ofs(cap_addr[OFS_W-1:0]), .wr_data(din),
      .clr(clr), .rd_ofs(pc[OFS_W-1:0]),
      .rd_valid(rd_valid), .rd_data(rd_data), .vmap(load_map)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         idle_cnt <= '0;
         pc       <= '0;
         page_q   <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (latch) begin
                  st       <= ST_LOAD;
                  page_q   <= cap_addr[ADDR_W-1:OFS_W];
                  idle_cnt <= '0;
               end
            end
            ST_LOAD: begin
               if (latch) begin
                  idle_cnt <= '0;
               end else if (idle_cnt == IC_W'(T_BLC - 1)) begin
                  st <= ST_PROG;
                  pc <= '0;
               end else begin
                  idle_cnt <= idle_cnt + 1'b1;
               end
            end
            ST_PROG: begin
               if (clr) st <= ST_IDLE;
               else     pc <= pc + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_we   <= 1'b0;
         commit_addr <= '0;
         commit_data <= '0;
      end else begin
         commit_we   <= prog && (pc < PC_W'(PAGE_BYTES)) && rd_valid;
         commit_addr <= {page_q, pc[OFS_W-1:0]};
         commit_data <= rd_data;
      end
   end

   assign busy = (st != ST_IDLE);
endmodule

// File: rtl/eepc_checker.sv
module eepc_checker #(
   parameter int PAGE_BYTES = 128
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  busy,
   input logic                  commit_we,
   input logic                  por_ok,
   input logic                  oe_f,
   input logic                  prog,
   input logic [PAGE_BYTES-1:0] load_map
);
   AST_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      commit_we |-> busy); // R5
   AST_MAP_EMPTY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (load_map == '0)); // R5
   AST_START_NEEDS_POR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(por_ok)); // R8
   AST_START_NEEDS_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(oe_f)); // R6
   AST_BUSY_ENDS_FROM_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(prog)); // R9
   AST_MAP_FROZEN_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      (prog && $past(prog)) |-> $stable(load_map)); // R10
endmodule

bind eeprom_page_prog eepc_checker #(.PAGE_BYTES(1 << OFS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .commit_we(commit_we),
   .por_ok(por_ok), .oe_f(oe_f), .prog(prog), .load_map(load_map)
);

// File: tb/sim_eeprom_page_prog.sv
`timescale 1ns/1ps
module sim_eeprom_page_prog;
   localparam int FILT = 2, TBLC = 40, TWC = 200, TPOR = 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        supply_good = 1'b1;
   logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [16:0] addr = '0;
   logic [7:0]  din = '0;
   logic        busy, commit_we;
   logic [16:0] commit_addr;
   logic [7:0]  commit_data;

   eeprom_page_prog #(.FILT_CYC(FILT), .T_BLC(TBLC), .T_WC(TWC), .T_POR(TPOR)) u0 (
      .clk(clk), .rst_n(rst_n), .supply_good(supply_good),
      .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
      .busy(busy), .commit_we(commit_we), .commit_addr(commit_addr),
      .commit_data(commit_data)
   );

   always #10 clk = ~clk;

   int   errors = 0, total = 0;
   bit   done = 0;
   bit   exp_v [128];
   logic [7:0] exp_d [128];
   bit   got_v [128];
   logic [7:0] got_d [128];
   logic [9:0] exp_page;
   int   ncommit = 0, page_bad = 0, busy_cnt = 0;

   function automatic logic [16:0] exp_caddr(input logic [9:0] pg, input logic [6:0] ofs);
      return {pg, ofs};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (busy) busy_cnt++;
      if (commit_we) begin
         ncommit++;
         got_v[commit_addr[6:0]] = 1'b1;
         got_d[commit_addr[6:0]] = commit_data;
         if (commit_addr != exp_caddr(exp_page, commit_addr[6:0])) page_bad++;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [16:0] a, input logic [7:0] d, input bit ce_ctrl);
      @(negedge clk); addr = a; din = d;
      if (ce_ctrl) begin
         we_n = 0; cyc(2); ce_n = 0; cyc(6); ce_n = 1; cyc(4); we_n = 1;
      end else begin
         ce_n = 0; cyc(2); we_n = 0; cyc(6); we_n = 1; cyc(4); ce_n = 1;
      end
      cyc(2);
   endtask

   task automatic note(input logic [6:0] ofs, input logic [7:0] d);
      exp_v[ofs] = 1'b1; exp_d[ofs] = d;
   endtask

   task automatic begin_session(input logic [9:0] pg);
      for (int i = 0; i < 128; i++) begin
         exp_v[i] = 0; got_v[i] = 0; exp_d[i] = '0; got_d[i] = '0;
      end
      exp_page = pg; ncommit = 0; page_bad = 0; busy_cnt = 0;
   endtask

   task automatic wait_idle;
      for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
      cyc(2);
   endtask

   task automatic end_session(input string req);
      int n_exp, bad;
      wait_idle();
      n_exp = 0; bad = 0;
      for (int i = 0; i < 128; i++) begin
         if (exp_v[i]) n_exp++;
         if (exp_v[i] != got_v[i]) bad++;
         else if (exp_v[i] && exp_d[i] != got_d[i]) bad++;
      end
      chk(ncommit == n_exp, {req, " commit count"}, ncommit, n_exp);
      chk(bad == 0, {req, " byte contents"}, bad, 0);
      chk(page_bad == 0, {req, " commit page"}, page_bad, 0);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, total);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0000_5eed));
      begin_session(10'd0);
      cyc(4);
      rst_n = 1;
      @(negedge clk);
      // R11: reset state
      chk(busy == 0, "R11 busy after reset", busy, 0);
      chk(commit_we == 0, "R11 commit_we after reset", commit_we, 0);

      // R8: power-on lockout
      busy_cnt = 0;
      wr(17'h00100, 8'h11, 0);
      cyc(40);
      chk(busy_cnt == 0, "R8 write during power-on delay", busy_cnt, 0);
      supply_good = 0; cyc(3); supply_good = 1;
      cyc(60);
      wr(17'h00100, 8'h22, 0);
      cyc(10);
      chk(busy_cnt == 0, "R8 delay restarted after supply drop", busy_cnt, 0);
      cyc(150);

      // R1 R9: single WE-controlled byte, exact busy duration
      begin_session(10'h155);
      wr({10'h155, 7'd9}, 8'hA5, 0); note(7'd9, 8'hA5);
      end_session("R1 we-controlled");
      chk(busy_cnt == TBLC + TWC, "R9 busy duration", busy_cnt, TBLC + TWC);

      // R1 R3 R5: CE-controlled page, overwrite, foreign page bits ignored
      begin_session(10'h2A3);
      wr({10'h2A3, 7'd127}, 8'h01, 1); note(7'd127, 8'h01);
      wr({10'h2A3, 7'd0},   8'h02, 1); note(7'd0,   8'h02);
      wr({10'h011, 7'd64},  8'h03, 1); note(7'd64,  8'h03);
      wr({10'h2A3, 7'd0},   8'h04, 0); note(7'd0,   8'h04);
      end_session("R3 R5 ce-controlled page");

      // R2: address sampled at start, data at end
      begin_session(10'h0F0);
      @(negedge clk); addr = {10'h0F0, 7'd33}; din = 8'h5A;
      ce_n = 0; cyc(2); we_n = 0; cyc(5);
      addr = {10'h0F0, 7'd77}; din = 8'hC3;
      cyc(1); we_n = 1; cyc(4); ce_n = 1; cyc(2);
      note(7'd33, 8'hC3);
      end_session("R2 capture points");

      // R4 R10: gap closes the window; write in programming ignored
      begin_session(10'h300);
      wr({10'h300, 7'd5}, 8'h77, 0); note(7'd5, 8'h77);
      cyc(TBLC + 10);
      wr({10'h300, 7'd6}, 8'h88, 1);
      end_session("R4 gap closes window");
      busy_cnt = 0;
      cyc(30);
      chk(busy_cnt == 0, "R10 write in programming started no page", busy_cnt, 0);

      // R6: output-enable low inhibits
      begin_session(10'h001);
      oe_n = 0;
      wr({10'h001, 7'd1}, 8'h99, 0);
      cyc(20);
      oe_n = 1;
      cyc(4);
      chk(busy_cnt == 0, "R6 oe low write", busy_cnt, 0);

      // R7: short pulses ignored
      @(negedge clk); addr = {10'h001, 7'd2}; ce_n = 0; cyc(2);
      we_n = 0; cyc(1); we_n = 1; cyc(3); ce_n = 1; cyc(3);
      we_n = 0; cyc(2); ce_n = 0; cyc(1); ce_n = 1; cyc(3); we_n = 1;
      cyc(20);
      chk(busy_cnt == 0, "R7 glitch on strobes", busy_cnt, 0);

      // R5: full page, every offset
      begin_session(10'h3FF);
      for (int i = 0; i < 128; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         wr({10'h3FF, 7'(i)}, d, i[0]); note(7'(i), d);
      end
      end_session("R5 full page");

      // R1 R3 R5: random pages
      for (int s = 0; s < 6; s++) begin
         logic [9:0] pg;
         int n;
         pg = 10'($urandom);
         n  = 1 + int'($urandom % 20);
         begin_session(pg);
         for (int k = 0; k < n; k++) begin
            logic [6:0] o;
            logic [7:0] d;
            o = 7'($urandom); d = 8'($urandom);
            wr({pg, o}, d, 1'($urandom)); note(o, d);
         end
         end_session("R1 R3 R5 random page");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
   end
endmodule